// File: doc/BRIEF.md
# Streaming 3x3 Template Convolver

This block takes a raster stream of signed fixed-point pixels, one per clock when the input is valid. It keeps the two preceding image rows in flops, so a full 3x3 neighbourhood is present at every pixel. That neighbourhood is multiplied with a run-time loadable 3x3 template of signed coefficients, and the block produces one signed result per accepted pixel. Image width is a parameter. Image height is not needed: a frame-start flag on the first pixel of each frame restarts the position tracking.

Each result belongs to the window whose newest pixel is the accepted pixel, which puts the window centre one row up and one column left of that pixel. Window positions that lie before the first row or before the first column of the frame count as zero. A border flag marks every result whose window needed such padding.

Coefficients are written through an address/data/enable port into a staging bank. The staging bank is copied into the working bank only when a frame starts, so a single frame never mixes two templates.

Top module: `tmpl_conv3x3`

## Requirements
- R1: Each pixel accepted (pix_valid_i high at a rising edge) yields exactly one res_valid_o pulse, valid after the second rising edge that follows the accepting edge. Results leave in the order the pixels arrived.
- R2: With tap address k = 3*i + j, where i is the row (0 = two rows above the newest pixel, 2 = the newest pixel's row) and j is the column (0 = two columns left, 2 = the newest pixel's column), res_o equals floor(sum over k of coef[k]*pix[k] / 1024). Pixels are 12-bit signed Q1.10, coefficients are 14-bit signed Q3.10, and res_o is 18-bit signed Q7.10.
- R3: A window position whose row is above frame row 0 or whose column is left of column 0 contributes zero. Pixels from an earlier or truncated frame, or from the end of the previous row, never reach a result.
- R4: border_o is 1 alongside a result exactly when the newest pixel lies in frame row 0 or 1, or in column 0 or 1.
- R5: A written coefficient is clamped to the range -5120..+5120 (plus or minus 5.0). A value inside that range is stored unchanged.
- R6: A write to an address from 9 to 15 changes no coefficient.
- R7: A write goes to a staging bank. The working template is replaced by the staging bank only when a pixel is accepted with sof_i high, and it applies from that pixel's result onward. A write in the same cycle as that frame start reaches the working template only at the next frame start.
- R8: After reset, res_valid_o, res_o and border_o are 0, the working and staging templates are all zero, and the position is frame row 0, column 0.
- R9: Cycles with pix_valid_i low leave the position and the line buffers unchanged. The column wraps to 0 after column IMG_W-1 and the row then advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel present this cycle |
| sof_i | input | 1 | With pix_valid_i: this pixel is frame row 0, column 0 |
| pix_i | input | PIX_W (12) | Signed Q1.10 pixel |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | 4 | Tap address 0..8, row-major |
| coef_data_i | input | COEF_W (14) | Signed Q3.10 coefficient |
| res_valid_o | output | 1 | Result present |
| res_o | output | RES_W (18) | Signed Q7.10 convolution result |
| border_o | output | 1 | Result window used zero padding |

## Verification
A stream sent before any template is loaded checks that the reset template is zero. An asymmetric template with fractional weights, applied to pseudo-random pixels and to a single impulse, separates the tap order, the window orientation and floor rounding from a plain sum. Full-scale pixels combined with out-of-range and exactly-at-limit coefficients expose faults in clamping, sign extension and result width. Writes in the middle of a frame and on the frame-start cycle, unused addresses, random input gaps and a frame cut short in mid-row separate template switch timing, address decoding, stall behaviour and padding after a restart.

// File: rtl/tmpl_conv3x3_pkg.sv
package tmpl_conv3x3_pkg;
  localparam int unsigned KDIM   = 3;
  localparam int unsigned TAPS   = KDIM * KDIM;
  localparam int unsigned ADDR_W = 4;

  // distance of the newest pixel from the top/left frame edge, saturated
  typedef enum logic [1:0] {
    LVL_0 = 2'd0,
    LVL_1 = 2'd1,
    LVL_N = 2'd2
  } edge_lvl_e;
endpackage

// File: rtl/tmpl_conv3x3_coef.sv
module tmpl_conv3x3_coef
  import tmpl_conv3x3_pkg::*;
#(
  parameter int unsigned COEF_W   = 14,
  parameter int unsigned FRAC_W   = 10,
  parameter int unsigned COEF_MAG = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [COEF_W-1:0]            data_i,
  input  logic                         frame_start_i,
  output logic [TAPS-1:0][COEF_W-1:0]  coef_o
);
  localparam int LIM_I = int'(COEF_MAG) << FRAC_W;
  localparam logic signed [COEF_W-1:0] POS_LIM = COEF_W'(LIM_I);
  localparam logic signed [COEF_W-1:0] NEG_LIM = COEF_W'(-LIM_I);

  logic signed [COEF_W-1:0]        wr_val;
  logic [TAPS-1:0][COEF_W-1:0]     shd_q;
  logic [TAPS-1:0][COEF_W-1:0]     act_q;

  always_comb begin
    if ($signed(data_i) > POS_LIM)      wr_val = POS_LIM;
    else if ($signed(data_i) < NEG_LIM) wr_val = NEG_LIM;
    else                                wr_val = $signed(data_i);
  end

  // staging bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
    end else if (we_i) begin
      for (int k = 0; k < int'(TAPS); k++) begin
        if (addr_i == ADDR_W'(k)) shd_q[k] <= wr_val;
      end
    end
  end

  // working bank, swapped only at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            act_q <= '0;
    else if (frame_start_i) act_q <= shd_q;
  end

  assign coef_o = act_q;

  AST_BAD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i >= ADDR_W'(TAPS)) |=> $stable(shd_q)) else $error("bad address wrote"); // R6

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_q)) else $error("template changed mid-frame"); // R7

  for (genvar k = 0; k < int'(TAPS); k++) begin : g_rng
    AST_COEF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($signed(act_q[k]) <= POS_LIM) && ($signed(act_q[k]) >= NEG_LIM)) else $error("coef out of range"); // R5
  end
endmodule

// File: rtl/tmpl_conv3x3_win.sv
module tmpl_conv3x3_win
  import tmpl_conv3x3_pkg::*;
#(
  parameter int unsigned IMG_W = 16,
  parameter int unsigned PIX_W = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         vld_i,
  input  logic                         sof_i,
  input  logic [PIX_W-1:0]             pix_i,
  output logic                         vld_o,
  output logic                         border_o,
  output logic [TAPS-1:0][PIX_W-1:0]   win_o,
  output logic [TAPS-1:0]              ok_o
);
  localparam int unsigned COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam logic [COL_W-1:0] LAST = COL_W'(IMG_W - 1);

  logic [COL_W-1:0]   col_q, cur_col;
  edge_lvl_e          row_q, cur_row;
  edge_lvl_e          rlvl_q, clvl_q, clvl_d;
  logic               vld_q;

  logic [PIX_W-1:0]   line1_q [IMG_W];
  logic [PIX_W-1:0]   line2_q [IMG_W];
  logic [KDIM-1:0][PIX_W-1:0]            tap;
  logic [KDIM-1:0][KDIM-1:0][PIX_W-1:0]  win_q;
  logic [KDIM-1:0]    rok, cok;

  assign cur_col = sof_i ? '0 : col_q;
  assign cur_row = sof_i ? LVL_0 : row_q;

  assign tap[0] = line2_q[cur_col];
  assign tap[1] = line1_q[cur_col];
  assign tap[2] = pix_i;

  always_comb begin
    if (cur_col == '0)               clvl_d = LVL_0;
    else if (cur_col == COL_W'(1))   clvl_d = LVL_1;
    else                             clvl_d = LVL_N;
  end

  // position tracking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= LVL_0;
    end else if (vld_i) begin
      if (cur_col == LAST) begin
        col_q <= '0;
        row_q <= (cur_row == LVL_N) ? LVL_N : edge_lvl_e'(2'(cur_row) + 2'd1);
      end else begin
        col_q <= cur_col + COL_W'(1);
        row_q <= cur_row;
      end
    end
  end

  // two row buffers, no reset: stale content is masked by position
  always_ff @(posedge clk_i) begin
    if (vld_i) begin
      line2_q[cur_col] <= line1_q[cur_col];
      line1_q[cur_col] <= pix_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      rlvl_q <= LVL_0;
      clvl_q <= LVL_0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        for (int dr = 0; dr < int'(KDIM); dr++) begin
          win_q[dr] <= {tap[dr], win_q[dr][2:1]};
        end
        rlvl_q <= cur_row;
        clvl_q <= clvl_d;
      end
    end
  end

  for (genvar d = 0; d < int'(KDIM); d++) begin : g_lvl
    assign rok[d] = ({1'b0, rlvl_q} + 3'(d)) >= 3'd2;
    assign cok[d] = ({1'b0, clvl_q} + 3'(d)) >= 3'd2;
  end

  for (genvar dr = 0; dr < int'(KDIM); dr++) begin : g_row
    for (genvar dc = 0; dc < int'(KDIM); dc++) begin : g_col
      assign win_o[KDIM*dr+dc] = win_q[dr][dc];
      assign ok_o[KDIM*dr+dc]  = rok[dr] & cok[dc];
    end
  end

  assign vld_o    = vld_q;
  assign border_o = !((rlvl_q == LVL_N) && (clvl_q == LVL_N));

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(col_q) && $stable(row_q))) else $error("position moved on stall"); // R9

  AST_ROW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !sof_i && col_q == LAST) |=> (col_q == '0)) else $error("column did not wrap"); // R9

  AST_SOF_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sof_i) |=> (col_q == COL_W'(1) && row_q == LVL_0)) else $error("frame start not at origin"); // R3
endmodule

// File: rtl/tmpl_conv3x3_mac.sv
module tmpl_conv3x3_mac
  import tmpl_conv3x3_pkg::*;
#(
  parameter int unsigned PIX_W    = 12,
  parameter int unsigned COEF_W   = 14,
  parameter int unsigned FRAC_W   = 10,
  parameter int unsigned RES_W    = 18,
  parameter int unsigned COEF_MAG = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         vld_i,
  input  logic                         border_i,
  input  logic [TAPS-1:0][PIX_W-1:0]   win_i,
  input  logic [TAPS-1:0]              ok_i,
  input  logic [TAPS-1:0][COEF_W-1:0]  coef_i,
  output logic                         vld_o,
  output logic [RES_W-1:0]             res_o,
  output logic                         border_o
);
  localparam int unsigned PROD_W = PIX_W + COEF_W;
  localparam int unsigned SUM_W  = PROD_W + $clog2(TAPS);
  localparam longint BOUND = (longint'(TAPS) * (longint'(COEF_MAG) << FRAC_W)
                              * (longint'(1) << (PIX_W - 1))) >>> FRAC_W;

  logic signed [PROD_W-1:0] prod_q [TAPS];
  logic                     vld_a_q, brd_a_q;
  logic signed [SUM_W-1:0]  sum;
  logic [RES_W-1:0]         res_q;
  logic                     vld_q, brd_q;

  for (genvar k = 0; k < int'(TAPS); k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prod_q[k] <= '0;
      end else if (vld_i) begin
        if (ok_i[k]) prod_q[k] <= $signed(coef_i[k]) * $signed(win_i[k]);
        else         prod_q[k] <= '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_a_q <= 1'b0;
      brd_a_q <= 1'b0;
    end else begin
      vld_a_q <= vld_i;
      if (vld_i) brd_a_q <= border_i;
    end
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < int'(TAPS); k++) sum = sum + SUM_W'(prod_q[k]);
  end

  // drop fractional bits of the product sum (floor)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
      brd_q <= 1'b0;
    end else begin
      vld_q <= vld_a_q;
      if (vld_a_q) begin
        res_q <= RES_W'(sum >>> FRAC_W);
        brd_q <= brd_a_q;
      end
    end
  end

  assign vld_o    = vld_q;
  assign res_o    = res_q;
  assign border_o = brd_q;

  AST_RES_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (($signed(res_q) <= BOUND) && ($signed(res_q) >= -BOUND))) else $error("result beyond bound"); // R5
endmodule

// File: rtl/tmpl_conv3x3.sv
module tmpl_conv3x3
  import tmpl_conv3x3_pkg::*;
#(
  parameter int unsigned IMG_W    = 16,
  parameter int unsigned PIX_W    = 12,
  parameter int unsigned COEF_W   = 14,
  parameter int unsigned FRAC_W   = 10,
  parameter int unsigned RES_W    = 18,
  parameter int unsigned COEF_MAG = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pix_valid_i,
  input  logic               sof_i,
  input  logic [PIX_W-1:0]   pix_i,
  input  logic               coef_we_i,
  input  logic [ADDR_W-1:0]  coef_addr_i,
  input  logic [COEF_W-1:0]  coef_data_i,
  output logic               res_valid_o,
  output logic [RES_W-1:0]   res_o,
  output logic               border_o
);
  logic                         frame_start;
  logic [TAPS-1:0][COEF_W-1:0]  coef;
  logic [TAPS-1:0][PIX_W-1:0]   win;
  logic [TAPS-1:0]              ok;
  logic                         win_vld, win_brd;
  logic [1:0]                   age_q;

  assign frame_start = pix_valid_i & sof_i;

  tmpl_conv3x3_coef #(
    .COEF_W(COEF_W), .FRAC_W(FRAC_W), .COEF_MAG(COEF_MAG)
  ) u_coef (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(coef_we_i), .addr_i(coef_addr_i),
    .data_i(coef_data_i), .frame_start_i(frame_start), .coef_o(coef)
  );

  tmpl_conv3x3_win #(
    .IMG_W(IMG_W), .PIX_W(PIX_W)
  ) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(pix_valid_i), .sof_i(sof_i), .pix_i(pix_i),
    .vld_o(win_vld), .border_o(win_brd), .win_o(win), .ok_o(ok)
  );

  tmpl_conv3x3_mac #(
    .PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .RES_W(RES_W), .COEF_MAG(COEF_MAG)
  ) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(win_vld), .border_i(win_brd), .win_i(win),
    .ok_i(ok), .coef_i(coef), .vld_o(res_valid_o), .res_o(res_o), .border_o(border_o)
  );

  // cycles since reset, for the latency check only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (res_valid_o == $past(pix_valid_i, 3))) else $error("latency mismatch"); // R1
endmodule

// File: tb/tmpl_conv3x3_tb.sv
module tmpl_conv3x3_tb;
  localparam int W = 5;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        pix_valid_i, sof_i, coef_we_i;
  logic [11:0] pix_i;
  logic [3:0]  coef_addr_i;
  logic [13:0] coef_data_i;
  logic        res_valid_o, border_o;
  logic [17:0] res_o;

  always #5 clk = ~clk;

  tmpl_conv3x3 #(.IMG_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_valid_i(pix_valid_i), .sof_i(sof_i), .pix_i(pix_i),
    .coef_we_i(coef_we_i), .coef_addr_i(coef_addr_i), .coef_data_i(coef_data_i),
    .res_valid_o(res_valid_o), .res_o(res_o), .border_o(border_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;
  int act [9];
  int shd [9];
  int img [16][W];
  int mr = 0, mc = 0;
  longint q_res [$];
  bit     q_brd [$];
  int     q_stamp [$];
  string  q_req [$];

  int t1 [9] = '{1024, -512, 256, 2048, 3072, -1024, -256, 512, -3000};
  int t2 [9] = '{-5120, 77, 1, 4000, -2, 512, 333, -4444, 5120};
  int t3 [9] = '{700, -600, 500, -400, 300, -200, 100, -50, 25};
  int tc [9] = '{8191, 5120, -5121, 0, -8192, 5121, 1, -1, 3};

  task automatic chk(bit ok, string req, string what, longint a, longint e);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  function automatic int clampc(int d);
    if (d > 5120) return 5120;
    if (d < -5120) return -5120;
    return d;
  endfunction

  // output monitor, away from the active edge
  always @(posedge clk) begin : mon
    longint e;
    bit     b;
    int     s;
    string  rq;
    #2;
    cyc++;
    if (res_valid_o) begin
      if (q_res.size() == 0) begin
        chk(1'b0, "R1", "result without a pixel", 1, 0);
      end else begin
        e  = q_res.pop_front();
        b  = q_brd.pop_front();
        s  = q_stamp.pop_front();
        rq = q_req.pop_front();
        chk(longint'($signed(res_o)) == e, rq, "result value", longint'($signed(res_o)), e);
        chk(border_o == b, "R4", "border flag", longint'(border_o), longint'(b));
        chk(cyc - s == 3, "R1", "latency", cyc - s, 3);
      end
    end
  end

  task automatic step(bit v, bit s, int p, bit we, int a, int d, string req);
    @(negedge clk);
    pix_valid_i = v; sof_i = s; pix_i = 12'(p);
    coef_we_i = we; coef_addr_i = 4'(a); coef_data_i = 14'(d);
    if (v) begin
      longint acc;
      acc = 0;
      if (s) begin
        for (int k = 0; k < 9; k++) act[k] = shd[k];
        mr = 0; mc = 0;
      end
      img[mr][mc] = p;
      for (int dr = 0; dr < 3; dr++) begin
        for (int dc = 0; dc < 3; dc++) begin
          int rr, cc;
          rr = mr - 2 + dr;
          cc = mc - 2 + dc;
          if (rr >= 0 && cc >= 0) acc += longint'(act[3*dr+dc]) * longint'(img[rr][cc]);
        end
      end
      q_res.push_back(acc >>> 10);
      q_brd.push_back(mr < 2 || mc < 2);
      q_stamp.push_back(cyc);
      q_req.push_back(req);
      mc++;
      if (mc == W) begin mc = 0; mr++; end
    end
    if (we && a < 9) shd[a] = clampc(d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic load_tpl(input int t [9]);
    for (int k = 0; k < 9; k++) step(0, 0, 0, 1, k, t[k], "");
  endtask

  // mode 0 random, 1 full-scale, 2 impulse at row 2 col 2
  task automatic frame(int npix, bit sof_en, int mode, int gap, int wr_at,
                       int sof_a, int sof_d, string req);
    for (int i = 0; i < npix; i++) begin
      int p, a, d;
      bit we;
      if (gap > 0) while ($urandom_range(99) < gap) step(0, 0, 0, 0, 0, 0, req);
      case (mode)
        0: p = int'($urandom_range(4095)) - 2048;
        1: p = ($urandom_range(1) == 1) ? 2047 : -2048;
        default: p = (i == 2*W + 2) ? 1024 : 0;
      endcase
      we = 0; a = 0; d = 0;
      if (i == 0 && sof_a >= 0) begin we = 1; a = sof_a; d = sof_d; end
      if (wr_at >= 0 && i >= wr_at && i < wr_at + 9) begin we = 1; a = i - wr_at; d = t3[a]; end
      step(1, sof_en && (i == 0), p, we, a, d, req);
    end
  endtask

  initial begin
    for (int k = 0; k < 9; k++) begin act[k] = 0; shd[k] = 0; end
    rst_ni = 0; pix_valid_i = 0; sof_i = 0; pix_i = 0;
    coef_we_i = 0; coef_addr_i = 0; coef_data_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    chk(res_valid_o == 1'b0, "R8", "valid after reset", longint'(res_valid_o), 0);
    chk(res_o == '0, "R8", "result after reset", longint'(res_o), 0);
    chk(border_o == 1'b0, "R8", "border after reset", longint'(border_o), 0);

    // stream with the reset template, no frame start: all-zero results
    frame(7, 0, 0, 0, -1, -1, 0, "R8");
    idle(4);

    load_tpl(t1);
    frame(20, 1, 0, 0, -1, -1, 0, "R2");
    frame(20, 1, 2, 0, -1, -1, 0, "R2");

    load_tpl(tc);
    frame(20, 1, 1, 0, -1, -1, 0, "R5");

    for (int a = 9; a < 16; a++) step(0, 0, 0, 1, a, 4000, "R6");
    frame(15, 1, 0, 0, -1, -1, 0, "R6");

    load_tpl(t2);
    frame(25, 1, 0, 0, 6, -1, 0, "R7");
    frame(20, 1, 0, 0, -1, 4, -77, "R7");
    frame(15, 1, 0, 0, -1, -1, 0, "R7");

    frame(30, 1, 0, 50, -1, -1, 0, "R9");

    frame(8, 1, 0, 0, -1, -1, 0, "R3");
    frame(17, 1, 1, 0, -1, -1, 0, "R3");

    idle(6);
    chk(q_res.size() == 0, "R1", "results outstanding", q_res.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule